// File: doc/BRIEF.md
# Chainable Event Counter Bank

This block holds a configurable number of 32-bit event counters and one 64-bit cycle counter, all reached through a single-cycle register port: a write is taken on the clock edge when `wr_en` is high, and a read returns the addressed register combinationally on `rd_data`. Each event counter advances on its own event pulse input and, when its event type is the software-increment code, on a software-increment register write. The cycle counter advances once per clock while it is enabled.

An even counter and the odd counter just above it can act as one 64-bit counter. This happens when the odd counter holds the chain event type and is enabled. The even counter then holds the low word and sets the event type and enable state. Its carry feeds the odd counter, and overflow is reported only on the odd counter. Overflow flags are sticky and appear on `ovf_o`. A control register holds the global enable and the long-cycle mode. Its write-only bits clear all event counters or the cycle counter. The number of implemented event counters is a parameter and can be read back from the control register.

Register map (7-bit addresses): 0x00 to 0x1E are the event counter values (index equals address). 0x1F is the cycle counter low word and 0x20 is its high word. 0x40+i is the event type of counter i. 0x60 is control, 0x61 enable-set, 0x62 enable-clear, 0x63 software increment and 0x64 the overflow flags.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset every counter, event type, enable bit, overflow flag, the global enable and the long-cycle bit are zero. A control read returns only the counter count N in bits [15:11].
- R2: The implemented mask has bits N-1..0 plus bit 31 (only bit 31 when N is 0). Enable-set (0x61) and overflow flags only ever hold masked bits. Reads of counter values or event types at unimplemented indices return 0.
- R3: An unchained event counter i advances by one on an event pulse `evt_i[i]` only while the global enable (control bit 0) and enable bit i are set. A wrap from 0xFFFFFFFF to 0 sets overflow flag i.
- R4: Pair p (counters 2p and 2p+1) is chained only while counter 2p+1 has event type 0x01E and is enabled (global enable and its enable bit). Otherwise both counters count independently.
- R5: In a chained pair, the odd counter ignores its own event pulses and software increments. It advances by the carry out of the even counter, and only its own wrap sets flag 2p+1. The even counter's wrap sets no flag.
- R6: A write to 0x63 advances each counter i whose data bit i is set, only when the global enable is set, enable bit i is set and its event type is 0x000. Bit 31 has no effect.
- R7: An event pulse and a software increment on the same counter in the same cycle advance it by two.
- R8: While the global enable and enable bit 31 are set, the cycle counter advances by one every clock as a 64-bit value. Flag 31 is set on a 64-bit wrap when control bit 3 (long-cycle) is set, and on a wrap of the low 32 bits otherwise.
- R9: A control write with bit 1 set clears all event counters. A control write with bit 2 set clears the cycle counter. Bits 0 and 3 are stored.
- R10: Overflow flags are sticky. Writing 0x64 clears the flags whose data bits are 1, and a flag set in the same cycle stays set.
- R11: A register write to a counter word, or a clear, replaces that word's value for the cycle. That cycle's increment of the word, its carry into the high half and its overflow flag are dropped.
- R12: Writing 0x61 sets the enable bits given by 1s in the data. Writing 0x62 clears them. Reading either address returns the enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | N (min 1) | Event pulses, one per event counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 7 | Register read address |
| rd_data | output | 32 | Combinational readback of the addressed register |
| ovf_o | output | 32 | Sticky overflow flags, bit index equals counter index |

## Verification
On every cycle the assertions check the following. A chained pair never raises the low counter's flag and holds its high word while no carry is possible. Counters hold while the global enable is off. The cycle counter steps by exactly one or holds. Overflow flags only fall through a clear write and never appear outside the implemented mask. The bench's scenarios show behaviour that needs chosen values: carries across the pair boundary, the exact chaining condition, the software-increment gates, the double step, the 32/64-bit cycle wrap point and the write-wins rule. A behavioural model compares a rotating readback address and the flags on every clock during both the directed and random traffic.

// File: rtl/evt_bank_pkg.sv
package evt_bank_pkg;

    localparam int unsigned CNT_W  = 32;
    localparam int unsigned ADDR_W = 7;
    localparam int unsigned CYC_IDX = 31;

    localparam logic [ADDR_W-1:0] A_CYC_LO    = 7'h1F;
    localparam logic [ADDR_W-1:0] A_CYC_HI    = 7'h20;
    localparam logic [ADDR_W-1:0] A_TYPE_BASE = 7'h40;
    localparam logic [ADDR_W-1:0] A_CTRL      = 7'h60;
    localparam logic [ADDR_W-1:0] A_EN_SET    = 7'h61;
    localparam logic [ADDR_W-1:0] A_EN_CLR    = 7'h62;
    localparam logic [ADDR_W-1:0] A_SW_INC    = 7'h63;
    localparam logic [ADDR_W-1:0] A_OVF       = 7'h64;

    // control bit positions
    localparam int unsigned C_EN    = 0;
    localparam int unsigned C_PCLR  = 1;
    localparam int unsigned C_CCLR  = 2;
    localparam int unsigned C_LONG  = 3;

    function automatic logic [CNT_W-1:0] impl_mask(int unsigned n);
        logic [CNT_W-1:0] m;
        m = '0;
        m[CYC_IDX] = 1'b1;
        for (int i = 0; i < int'(CYC_IDX); i++) begin
            if (i < int'(n)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/evt_pair_unit.sv
module evt_pair_unit #(
    parameter int unsigned    EVT_W      = 10,
    parameter logic [EVT_W-1:0] CHAIN_CODE = 10'h01E,
    parameter logic [EVT_W-1:0] SWINC_CODE = 10'h000,
    parameter bit             HAS_HI     = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glob_en,
    input  logic             en_lo,
    input  logic             en_hi,
    input  logic [EVT_W-1:0] type_lo,
    input  logic [EVT_W-1:0] type_hi,
    input  logic             evt_lo,
    input  logic             evt_hi,
    input  logic             sw_lo,
    input  logic             sw_hi,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [31:0]      wdata,
    input  logic             clr,
    output logic [31:0]      cnt_lo,
    output logic [31:0]      cnt_hi,
    output logic             ovf_lo,
    output logic             ovf_hi
);

    typedef struct packed {
        logic [31:0] lo;
        logic [31:0] hi;
    } pair_st_t;

    pair_st_t st_d, st_q;

    logic        act_lo, act_hi, chain;
    logic        swk_lo, swk_hi;
    logic [1:0]  inc_lo, inc_hi;
    logic [32:0] sum_lo, sum_hi;
    logic        carry_eff;

    always_comb begin
        act_lo    = glob_en & en_lo;
        act_hi    = HAS_HI & glob_en & en_hi;
        chain     = act_hi & (type_hi == CHAIN_CODE);
        swk_lo    = sw_lo & act_lo & (type_lo == SWINC_CODE);
        swk_hi    = sw_hi & act_hi & (type_hi == SWINC_CODE);
        inc_lo    = act_lo ? ({1'b0, evt_lo} + {1'b0, swk_lo}) : 2'd0;
        sum_lo    = {1'b0, st_q.lo} + {31'd0, inc_lo};
        carry_eff = sum_lo[32] & ~wr_lo & ~clr;
        if (chain)
            inc_hi = {1'b0, carry_eff};
        else
            inc_hi = act_hi ? ({1'b0, evt_hi} + {1'b0, swk_hi}) : 2'd0;
        sum_hi    = {1'b0, st_q.hi} + {31'd0, inc_hi};

        ovf_lo    = carry_eff & ~chain;
        ovf_hi    = HAS_HI & sum_hi[32] & ~wr_hi & ~clr;

        st_d.lo   = sum_lo[31:0];
        st_d.hi   = HAS_HI ? sum_hi[31:0] : 32'd0;
        if (clr) begin
            st_d.lo = '0;
            st_d.hi = '0;
        end
        if (wr_lo) st_d.lo = wdata;
        if (wr_hi && HAS_HI) st_d.hi = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_lo = st_q.lo;
    assign cnt_hi = st_q.hi;

    // R5
    chain_lo_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain |-> !ovf_lo);

    // R5
    chain_hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chain && cnt_lo < 32'hFFFF_FFFE && !wr_hi && !clr) |=> $stable(cnt_hi));

    // R3
    global_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en && !wr_lo && !wr_hi && !clr) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

endmodule

// File: rtl/evt_cycle_unit.sv
module evt_cycle_unit (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        glob_en,
    input  logic        en_bit,
    input  logic        long_mode,
    input  logic        clr,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    output logic [63:0] cnt,
    output logic        ovf
);

    typedef struct packed {
        logic [63:0] cnt;
    } cyc_st_t;

    cyc_st_t     st_d, st_q;
    logic        act;
    logic [64:0] sum;

    always_comb begin
        act      = glob_en & en_bit;
        sum      = {1'b0, st_q.cnt} + {64'd0, act};
        ovf      = act & ~wr_lo & ~wr_hi & ~clr &
                   (long_mode ? sum[64] : (st_q.cnt[31:0] == 32'hFFFF_FFFF));
        st_d.cnt = sum[63:0];
        if (clr)   st_d.cnt = '0;
        if (wr_lo) st_d.cnt = {st_q.cnt[63:32], wdata};
        if (wr_hi) st_d.cnt = {wdata, st_q.cnt[31:0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    // R8
    cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (glob_en && en_bit && !clr && !wr_lo && !wr_hi) |=> (cnt == $past(cnt) + 64'd1));

    // R8
    cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(glob_en && en_bit) && !clr && !wr_lo && !wr_hi) |=> $stable(cnt));

endmodule

// File: rtl/evt_counter_bank.sv
module evt_counter_bank
    import evt_bank_pkg::*;
#(
    parameter int unsigned      N_CNT      = 6,
    parameter int unsigned      EVT_W      = 10,
    parameter logic [EVT_W-1:0] CHAIN_CODE = 10'h01E,
    parameter logic [EVT_W-1:0] SWINC_CODE = 10'h000
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [((N_CNT == 0) ? 1 : N_CNT)-1:0] evt_i,
    input  logic                                  wr_en,
    input  logic [6:0]                            wr_addr,
    input  logic [31:0]                           wr_data,
    input  logic [6:0]                            rd_addr,
    output logic [31:0]                           rd_data,
    output logic [31:0]                           ovf_o
);

    localparam int unsigned NS        = (N_CNT == 0) ? 1 : N_CNT;
    localparam int unsigned NPAIR     = (N_CNT + 1) / 2;
    localparam logic [31:0] IMPL_MASK = impl_mask(N_CNT);
    localparam logic [4:0]  N_FIELD   = 5'(N_CNT);

    typedef struct packed {
        logic                       en;
        logic                       lc;
        logic [31:0]                cnten;
        logic [31:0]                ovf;
        logic [NS-1:0][EVT_W-1:0]   types;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic [31:0]   cnt_arr [NS];
    logic [NS-1:0] ovf_evt;
    logic [NS-1:0] cnt_wr;
    logic [31:0]   sw_bits;
    logic [31:0]   ovf_hit;
    logic [31:0]   ovf_clr;
    logic [63:0]   cyc_cnt;
    logic          ovf_cyc;
    logic          wr_ctrl;

    always_comb begin
        wr_ctrl = wr_en && (wr_addr == A_CTRL);
        sw_bits = (wr_en && (wr_addr == A_SW_INC)) ? wr_data : 32'd0;
        ovf_clr = (wr_en && (wr_addr == A_OVF)) ? wr_data : 32'd0;
        for (int i = 0; i < int'(NS); i++)
            cnt_wr[i] = wr_en && (wr_addr == 7'(i)) && (i < int'(N_CNT));
    end

    for (genvar p = 0; p < int'(NPAIR); p++) begin : g_pair
        localparam int  LO     = 2 * p;
        localparam bit  HAS_HI = (2 * p + 1) < int'(N_CNT);
        localparam int  HI     = HAS_HI ? (2 * p + 1) : (2 * p);
        logic [31:0] c_lo, c_hi;
        logic        o_lo, o_hi;

        evt_pair_unit #(
            .EVT_W(EVT_W), .CHAIN_CODE(CHAIN_CODE),
            .SWINC_CODE(SWINC_CODE), .HAS_HI(HAS_HI)
        ) u_pair (
            .clk(clk), .rst_n(rst_n), .glob_en(st_q.en),
            .en_lo(st_q.cnten[LO]), .en_hi(st_q.cnten[HI]),
            .type_lo(st_q.types[LO]), .type_hi(st_q.types[HI]),
            .evt_lo(evt_i[LO]), .evt_hi(evt_i[HI]),
            .sw_lo(sw_bits[LO]), .sw_hi(sw_bits[HI]),
            .wr_lo(cnt_wr[LO]), .wr_hi(cnt_wr[HI] && HAS_HI),
            .wdata(wr_data), .clr(wr_ctrl && wr_data[C_PCLR]),
            .cnt_lo(c_lo), .cnt_hi(c_hi), .ovf_lo(o_lo), .ovf_hi(o_hi)
        );

        assign cnt_arr[LO] = c_lo;
        assign ovf_evt[LO] = o_lo;
        if (HAS_HI) begin : g_hi
            assign cnt_arr[HI] = c_hi;
            assign ovf_evt[HI] = o_hi;
        end
    end

    evt_cycle_unit u_cycle (
        .clk(clk), .rst_n(rst_n), .glob_en(st_q.en),
        .en_bit(st_q.cnten[CYC_IDX]), .long_mode(st_q.lc),
        .clr(wr_ctrl && wr_data[C_CCLR]),
        .wr_lo(wr_en && (wr_addr == A_CYC_LO)),
        .wr_hi(wr_en && (wr_addr == A_CYC_HI)),
        .wdata(wr_data), .cnt(cyc_cnt), .ovf(ovf_cyc)
    );

    always_comb begin
        ovf_hit            = '0;
        ovf_hit[NS-1:0]    = ovf_evt;
        ovf_hit[CYC_IDX]   = ovf_cyc;
        ovf_hit            = ovf_hit & IMPL_MASK;

        st_d = st_q;
        if (wr_ctrl) begin
            st_d.en = wr_data[C_EN];
            st_d.lc = wr_data[C_LONG];
        end
        if (wr_en && (wr_addr == A_EN_SET))
            st_d.cnten = st_q.cnten | (wr_data & IMPL_MASK);
        if (wr_en && (wr_addr == A_EN_CLR))
            st_d.cnten = st_q.cnten & ~wr_data;
        for (int i = 0; i < int'(N_CNT); i++) begin
            if (wr_en && (wr_addr == A_TYPE_BASE + 7'(i)))
                st_d.types[i] = wr_data[EVT_W-1:0];
        end
        st_d.ovf = (st_q.ovf & ~ovf_clr) | ovf_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CYC_LO) begin
            rd_data = cyc_cnt[31:0];
        end else if (rd_addr == A_CYC_HI) begin
            rd_data = cyc_cnt[63:32];
        end else if (rd_addr == A_CTRL) begin
            rd_data = {16'd0, N_FIELD, 7'd0, st_q.lc, 2'b00, st_q.en};
        end else if (rd_addr == A_EN_SET || rd_addr == A_EN_CLR) begin
            rd_data = st_q.cnten;
        end else if (rd_addr == A_OVF) begin
            rd_data = st_q.ovf;
        end else begin
            for (int i = 0; i < int'(N_CNT); i++) begin
                if (rd_addr == 7'(i))
                    rd_data = cnt_arr[i];
                if (rd_addr == A_TYPE_BASE + 7'(i))
                    rd_data = {{(32-EVT_W){1'b0}}, st_q.types[i]};
            end
        end
    end

    assign ovf_o = st_q.ovf;

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_OVF) |=> ((ovf_o & $past(ovf_o)) == $past(ovf_o)));

    // R2
    ovf_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o & ~IMPL_MASK) == 32'd0);

    if (N_CNT > 0) begin : g_pclr_chk
        // R9
        p_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == A_CTRL && wr_data[C_PCLR]) |=> (cnt_arr[0] == 32'd0));
    end

endmodule

// File: tb/evt_counter_bank_test.sv
module evt_counter_bank_test;

    localparam int N = 6;
    localparam logic [9:0] CHAIN = 10'h01E;
    localparam logic [9:0] SWI   = 10'h000;
    localparam logic [31:0] MASK = 32'h8000_003F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] evt_i = '0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [6:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] ovf_o;

    always #4 clk = ~clk;

    evt_counter_bank #(.N_CNT(N)) uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .ovf_o(ovf_o)
    );

    // behavioural reference state
    logic [31:0] m_cnt [32];
    logic [63:0] m_cyc;
    logic [9:0]  m_typ [32];
    logic        m_en, m_lc;
    logic [31:0] m_cen, m_ovf;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [6:0] ra);
        if (ra == 7'h1F) return m_cyc[31:0];
        if (ra == 7'h20) return m_cyc[63:32];
        if (ra < 7'd32) return (int'(ra) < N) ? m_cnt[ra] : 32'd0;
        if (ra >= 7'h40 && ra < 7'h60) return (int'(ra - 7'h40) < N) ? {22'd0, m_typ[ra - 7'h40]} : 32'd0;
        if (ra == 7'h60) return {16'd0, 5'(N), 7'd0, m_lc, 2'b00, m_en};
        if (ra == 7'h61 || ra == 7'h62) return m_cen;
        if (ra == 7'h64) return m_ovf;
        return 32'd0;
    endfunction

    function automatic string tag_of(input logic [6:0] ra);
        if (ra < 7'h1F) return "R3";
        if (ra == 7'h1F || ra == 7'h20) return "R8";
        if (ra >= 7'h40 && ra < 7'h60) return "R2";
        if (ra == 7'h60) return "R9";
        if (ra == 7'h61 || ra == 7'h62) return "R12";
        return "R10";
    endfunction

    task automatic model_step(input bit w, input logic [6:0] a, input logic [31:0] d, input logic [N-1:0] e);
        logic [31:0] nc [32];
        logic [63:0] ncy;
        logic [31:0] sets, sw;
        bit clr_e;
        sw = (w && a == 7'h63) ? d : 32'd0;
        clr_e = w && a == 7'h60 && d[1];
        sets = '0;
        for (int i = 0; i < 32; i++) nc[i] = m_cnt[i];
        for (int p = 0; 2 * p < N; p++) begin
            int lo, hi, inc_l, inc_h;
            bit has_hi, act_l, act_h, chain, carry;
            longint unsigned v;
            lo = 2 * p; hi = 2 * p + 1; has_hi = hi < N;
            act_l = m_en && m_cen[lo];
            act_h = has_hi && m_en && m_cen[hi];
            chain = act_h && m_typ[hi] == CHAIN;
            inc_l = act_l ? (int'(e[lo]) + int'(sw[lo] && m_typ[lo] == SWI)) : 0;
            v = longint'(m_cnt[lo]) + inc_l;
            carry = (v >= 64'h1_0000_0000) && !(w && a == 7'(lo)) && !clr_e;
            nc[lo] = v[31:0];
            if (carry && !chain) sets[lo] = 1'b1;
            if (has_hi) begin
                if (chain) inc_h = int'(carry);
                else inc_h = act_h ? (int'(e[hi]) + int'(sw[hi] && m_typ[hi] == SWI)) : 0;
                v = longint'(m_cnt[hi]) + inc_h;
                nc[hi] = v[31:0];
                if (v >= 64'h1_0000_0000 && !(w && a == 7'(hi)) && !clr_e) sets[hi] = 1'b1;
            end
        end
        ncy = m_cyc;
        if (m_en && m_cen[31]) begin
            ncy = m_cyc + 64'd1;
            if ((m_lc ? (ncy == 64'd0) : (ncy[31:0] == 32'd0)) &&
                !(w && (a == 7'h1F || a == 7'h20)) && !(w && a == 7'h60 && d[2]))
                sets[31] = 1'b1;
        end
        if (w) begin
            if (int'(a) < N) nc[a] = d;
            if (a == 7'h1F) ncy = {m_cyc[63:32], d};
            if (a == 7'h20) ncy = {d, m_cyc[31:0]};
            if (a >= 7'h40 && int'(a - 7'h40) < N) m_typ[a - 7'h40] = d[9:0];
            if (a == 7'h60) begin
                m_en = d[0]; m_lc = d[3];
                if (d[1]) for (int i = 0; i < N; i++) nc[i] = 32'd0;
                if (d[2]) ncy = 64'd0;
            end
            if (a == 7'h61) m_cen = m_cen | (d & MASK);
            if (a == 7'h62) m_cen = m_cen & ~d;
            if (a == 7'h64) m_ovf = m_ovf & ~d;
        end
        m_ovf = m_ovf | sets;
        for (int i = 0; i < 32; i++) m_cnt[i] = nc[i];
        m_cyc = ncy;
    endtask

    task automatic step(input bit w, input logic [6:0] a, input logic [31:0] d,
                        input logic [N-1:0] e, input logic [6:0] ra);
        wr_en = w; wr_addr = a; wr_data = d; evt_i = e; rd_addr = ra;
        @(posedge clk);
        model_step(w, a, d, e);
        #2;
        chk(tag_of(ra), rd_data, m_read(ra));
        chk("R10", ovf_o, m_ovf);
        @(negedge clk);
        wr_en = 1'b0; evt_i = '0;
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        step(1'b1, a, d, '0, a);
    endtask

    task automatic rd(input logic [6:0] ra);
        step(1'b0, 7'd0, 32'd0, '0, ra);
    endtask

    initial begin
        #800000;
        if (!done) begin
            errs++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) begin m_cnt[i] = '0; m_typ[i] = '0; end
        m_cyc = '0; m_en = 0; m_lc = 0; m_cen = '0; m_ovf = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd_addr = 7'h60; #1;
        chk("R1", rd_data, 32'h0000_3000);
        chk("R1", ovf_o, 32'd0);
        rd_addr = 7'h00; #1;
        chk("R1", rd_data, 32'd0);

        // enables without global enable
        wr(7'h61, 32'h8000_0007);
        step(1'b0, 0, 0, 6'h3F, 7'h00);
        chk("R3", rd_data, 32'd0);
        wr(7'h60, 32'h1);
        repeat (3) step(1'b0, 0, 0, 6'b000001, 7'h00);
        chk("R3", rd_data, 32'd3);

        // mask and enable set/clear
        wr(7'h61, 32'hFFFF_FFFF);
        chk("R2", rd_data, 32'h8000_003F);
        wr(7'h62, 32'h0000_0038);
        chk("R12", rd_data, 32'h8000_0007);
        rd(7'h07);
        chk("R2", rd_data, 32'd0);
        rd(7'h47);
        chk("R2", rd_data, 32'd0);

        // unchained wrap
        wr(7'h02, 32'hFFFF_FFFF);
        step(1'b0, 0, 0, 6'b000100, 7'h02);
        chk("R3", rd_data, 32'd0);
        chk("R3", {31'd0, ovf_o[2]}, 32'd1);
        wr(7'h64, 32'h4);
        chk("R10", {31'd0, ovf_o[2]}, 32'd0);

        // chaining pair 0
        wr(7'h41, 32'h1E);
        wr(7'h00, 32'hFFFF_FFFF);
        wr(7'h01, 32'd5);
        step(1'b0, 0, 0, 6'b000011, 7'h01);
        chk("R5", rd_data, 32'd6);
        rd(7'h00);
        chk("R5", rd_data, 32'd0);
        chk("R5", {30'd0, ovf_o[1:0]}, 32'd0);

        // odd disabled: pair splits
        wr(7'h62, 32'h2);
        wr(7'h00, 32'hFFFF_FFFF);
        step(1'b0, 0, 0, 6'b000001, 7'h01);
        chk("R4", rd_data, 32'd6);
        chk("R4", {31'd0, ovf_o[0]}, 32'd1);
        wr(7'h64, 32'h1);
        wr(7'h61, 32'h2);
        wr(7'h01, 32'hFFFF_FFFF);
        wr(7'h00, 32'hFFFF_FFFF);
        step(1'b0, 0, 0, 6'b000001, 7'h01);
        chk("R5", rd_data, 32'd0);
        chk("R5", {30'd0, ovf_o[1:0]}, 32'd2);
        wr(7'h64, 32'h2);

        // software increment
        wr(7'h02, 32'd10);
        wr(7'h63, 32'h4);
        rd(7'h02);
        chk("R6", rd_data, 32'd11);
        wr(7'h42, 32'd5);
        wr(7'h63, 32'h4);
        rd(7'h02);
        chk("R6", rd_data, 32'd11);
        wr(7'h42, 32'd0);
        wr(7'h63, 32'h8);
        rd(7'h03);
        chk("R6", rd_data, 32'd0);
        wr(7'h60, 32'h0);
        wr(7'h63, 32'h4);
        rd(7'h02);
        chk("R6", rd_data, 32'd11);
        wr(7'h60, 32'h1);
        wr(7'h01, 32'd7);
        wr(7'h00, 32'hFFFF_FFFF);
        wr(7'h63, 32'h3);
        rd(7'h01);
        chk("R6", rd_data, 32'd8);
        rd(7'h00);
        chk("R6", rd_data, 32'd0);

        // double step and write priority
        step(1'b1, 7'h63, 32'h4, 6'b000100, 7'h02);
        chk("R7", rd_data, 32'd13);
        step(1'b1, 7'h02, 32'd100, 6'b000100, 7'h02);
        chk("R11", rd_data, 32'd100);

        // control clears
        wr(7'h60, 32'h3);
        rd(7'h02);
        chk("R9", rd_data, 32'd0);
        step(1'b1, 7'h60, 32'h5, '0, 7'h1F);
        chk("R9", rd_data, 32'd0);
        rd(7'h1F);
        chk("R8", rd_data, 32'd1);

        // cycle counter 32-bit overflow point
        wr(7'h1F, 32'hFFFF_FFF0);
        repeat (16) rd(7'h20);
        chk("R8", rd_data, 32'd1);
        chk("R8", {31'd0, ovf_o[31]}, 32'd1);
        wr(7'h64, 32'h8000_0000);
        wr(7'h60, 32'h9);
        wr(7'h1F, 32'hFFFF_FFF0);
        repeat (16) rd(7'h20);
        chk("R8", rd_data, 32'd2);
        chk("R8", {31'd0, ovf_o[31]}, 32'd0);
        wr(7'h20, 32'hFFFF_FFFF);
        wr(7'h1F, 32'hFFFF_FFF0);
        repeat (16) rd(7'h20);
        chk("R8", rd_data, 32'd0);
        chk("R8", {31'd0, ovf_o[31]}, 32'd1);

        // random traffic against the model
        for (int k = 0; k < 3000; k++) begin
            logic [6:0] addrs [16];
            logic [6:0] a, ra;
            logic [31:0] d;
            bit w;
            addrs = '{7'h00, 7'h01, 7'h02, 7'h03, 7'h04, 7'h05, 7'h1F, 7'h20,
                      7'h40, 7'h41, 7'h43, 7'h60, 7'h61, 7'h62, 7'h63, 7'h64};
            a  = addrs[$urandom % 16];
            ra = addrs[$urandom % 16];
            w  = ($urandom % 3) == 0;
            d  = $urandom;
            if (a < 7'h20) d = 32'hFFFF_FFF0 | (d & 32'hF);
            if (a >= 7'h40 && a < 7'h60) d = (d[0]) ? 32'h1E : ((d[1]) ? 32'd5 : 32'd0);
            if (a == 7'h60) d = {28'd0, d[3:1], 1'b1};
            step(w, a, d, N'($urandom), ra);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule